// File: doc/BRIEF.md
# Touch Panel Driver and Pen-Interrupt Controller

This block sits between the serial command sequencer of a resistive touch-panel digitizer and its analog front end. It holds the channel, reference-mode and power-management fields of the last complete command word. From those fields and the phase strobes of the sequencer it produces four things: the enables of the four panel drive switches, the input multiplexer select, the ratiometric reference select and an analog power-down flag.

It also owns the pen-interrupt pin. Between commands, and when the power field enables it, the open-drain pull-down follows the touch comparator. Once a start bit is seen the pin is frozen. From acquisition onward it is released. After the conversion it re-arms only if the power field then in force allows it.

Switch timing depends on the mode. In single-ended mode the drivers are on only while the input is being acquired. In differential mode they stay on for the whole conversion. With the "always powered, pen off" power code they stay on across commands until any field of the command word changes.

Top module: `panel_drive_ctrl`

## Requirements
- R1: After reset the power field is 2'b10 (bit 1 = keep powered, bit 0 = pen disabled), single-ended mode is selected and the channel code is 3'b000. The outputs are therefore: `chan_invalid`=1, `analog_pd`=0, `pen_pull`=0, `mux_sel`=0, and of the drivers only `drv_yn` is on (pen sensing).
- R2: Channel code 3'b001 gives `mux_sel`=0 (X+ input) and drives Y+/Y−. Code 3'b101 gives `mux_sel`=1 (Y+ input) and drives X+/X−. Codes 3'b010 and 3'b110 give `mux_sel`=2 and 3 (first and second auxiliary input) and leave all drivers off.
- R3: Channel codes 3'b000, 3'b011, 3'b100 and 3'b111 are invalid, and so is an auxiliary code with `cfg_single`=0. An invalid code sets `chan_invalid`, forces `mux_sel`=0 and keeps every driver off during a command.
- R4: In single-ended mode (`cfg_single`=1), with any power code other than 2'b11, the selected drivers come on in the cycle after an accepted acquire strobe and go off in the cycle after the hold strobe.
- R5: In differential mode (`cfg_single`=0) the selected drivers stay on from the acquire strobe until the cycle after the end-of-conversion strobe.
- R6: `ref_ratio` is 1 exactly when differential mode is selected with channel 3'b001 or 3'b101.
- R7: `analog_pd` is 1 between commands (idle, or start seen but not yet acquiring) when power bit 1 is 0. It is 0 during acquisition and conversion, and whenever power bit 1 is 1.
- R8: Between commands, with no held drivers, `drv_yn` is on when power bit 0 is 0 (pen sensing) and off when it is 1.
- R9: With power code 2'b11 and an X or Y channel, the drivers stay on through hold and after end of conversion. They stay on until a `cfg_load` carries a field different from the stored word. Reloading an identical word keeps them on.
- R10: In idle, `pen_pull` equals `pen_touch` when power bit 0 is 0, and is 0 when it is 1.
- R11: An accepted start strobe freezes `pen_pull` at its current value, and touch changes are ignored. From the acquire strobe until end of conversion `pen_pull` is 0.
- R12: The command fields change only on `cfg_load`. Pen re-arming after end of conversion uses the power field in force at that moment, including a `cfg_load` in the same cycle as the end-of-conversion strobe.
- R13: Strobes out of order are ignored: acquire outside the start-seen state, hold outside acquisition, end of conversion outside conversion, and start outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Complete command word present on cfg_* this cycle |
| cfg_chan | input | 3 | Channel code of the command word |
| cfg_single | input | 1 | 1 = single-ended reference, 0 = differential |
| cfg_pwr | input | 2 | Power field: bit 1 keep powered, bit 0 pen disabled |
| start_det | input | 1 | Start bit detected strobe |
| acq_go | input | 1 | Acquisition begins strobe |
| hold_go | input | 1 | Hold instant strobe |
| conv_done | input | 1 | End of conversion strobe |
| pen_touch | input | 1 | Touch comparator output, 1 = touched |
| drv_xp | output | 1 | X+ drive switch enable |
| drv_xn | output | 1 | X− drive switch enable |
| drv_yp | output | 1 | Y+ drive switch enable |
| drv_yn | output | 1 | Y− drive switch enable |
| mux_sel | output | 2 | Input select: 0 X+, 1 Y+, 2 aux one, 3 aux two |
| ref_ratio | output | 1 | 1 = reference taken across the driven panel |
| chan_invalid | output | 1 | Stored channel/mode combination is invalid |
| analog_pd | output | 1 | Analog section powered down |
| pen_pull | output | 1 | Pen-interrupt pull-down active |

## Verification
The end-of-conversion strobe and a command-word load can land in the same cycle. Two things are decided in that cycle: whether the pen re-arms, and whether the drivers latch on under power code 2'b11. The bench provokes this by raising `cfg_load` and `conv_done` together. It then judges `pen_pull` and the driver outputs against the newly loaded power field, not the old one. A second collision makes a touch edge coincide with the start strobe, and the bench checks that the frozen pin value is the one seen before the start.

// File: rtl/pdc_pkg.sv
// Package: shared phase encoding and command-field codes for the panel
// drive controller. Assumes a 3-bit channel code and 2-bit power field.
package pdc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_ACQ   = 2'd2,
        PH_CONV  = 2'd3
    } phase_t;

    localparam logic [2:0] CH_XPOS = 3'b001;
    localparam logic [2:0] CH_YPOS = 3'b101;
    localparam logic [2:0] CH_AUX1 = 3'b010;
    localparam logic [2:0] CH_AUX2 = 3'b110;

    localparam logic [1:0] PWR_HOLD_ON = 2'b11;
endpackage

// File: rtl/pdc_phase_fsm.sv
// Module: command phase tracker. Follows the sequencer strobes through
// idle, start-seen, acquire and convert. Assumes strobes are single-cycle;
// a strobe that does not match the current phase is ignored.
module pdc_phase_fsm
    import pdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_det,
    input  logic   acq_go,
    input  logic   hold_go,
    input  logic   conv_done,
    output phase_t phase,
    output logic   start_fire,
    output logic   done_fire
);
    phase_t phase_q;
    phase_t phase_d;

    // Qualify strobes against the phase in which they are legal.
    assign start_fire = (phase_q == PH_IDLE) && start_det;
    assign done_fire  = (phase_q == PH_CONV) && conv_done;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start_det) phase_d = PH_ARMED;
            PH_ARMED: if (acq_go)    phase_d = PH_ACQ;
            PH_ACQ:   if (hold_go)   phase_d = PH_CONV;
            PH_CONV:  if (conv_done) phase_d = PH_IDLE;
            default:                 phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;
endmodule

// File: rtl/pdc_cfg_regs.sv
// Module: command-field store and driver hold latch. Fields load only on
// cfg_load. The hold latch keeps drivers on after a conversion when the
// power field in force at end of conversion is the hold-on code.
module pdc_cfg_regs
    import pdc_pkg::*;
#(
    parameter int         CHAN_W       = 3,
    parameter int         PWR_W        = 2,
    parameter logic [2:0] CHAN_RESET   = 3'b000,
    parameter logic       SINGLE_RESET = 1'b1,
    parameter logic [1:0] PWR_RESET    = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              cfg_single,
    input  logic [PWR_W-1:0]  cfg_pwr,
    input  logic              done_fire,
    output logic [CHAN_W-1:0] chan_q,
    output logic              single_q,
    output logic [PWR_W-1:0]  pwr_q,
    output logic              keep_q
);
    localparam int CFG_W = CHAN_W + 1 + PWR_W;

    logic [CFG_W-1:0] word_q;
    logic [CFG_W-1:0] word_in;
    logic [CFG_W-1:0] word_nxt;
    logic             word_diff;
    logic             xy_nxt;
    logic             keep_d;

    assign word_in   = {cfg_chan, cfg_single, cfg_pwr};
    assign word_nxt  = cfg_load ? word_in : word_q;
    assign word_diff = cfg_load && (word_in != word_q);
    assign xy_nxt    = (word_nxt[CFG_W-1 -: CHAN_W] == CH_XPOS) ||
                       (word_nxt[CFG_W-1 -: CHAN_W] == CH_YPOS);

    // Hold latch: set or cleared at end of conversion, cleared on change.
    always_comb begin
        if (done_fire)
            keep_d = xy_nxt && (word_nxt[PWR_W-1:0] == PWR_HOLD_ON);
        else if (word_diff)
            keep_d = 1'b0;
        else
            keep_d = keep_q;
    end

    // Field and latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= {CHAN_RESET, SINGLE_RESET, PWR_RESET};
            keep_q <= 1'b0;
        end else begin
            word_q <= word_nxt;
            keep_q <= keep_d;
        end
    end

    assign chan_q   = word_q[CFG_W-1 -: CHAN_W];
    assign single_q = word_q[PWR_W];
    assign pwr_q    = word_q[PWR_W-1:0];
endmodule

// File: rtl/pdc_route.sv
// Module: decodes stored fields and the current phase into switch enables,
// mux select, reference select and analog power-down. Purely combinational;
// assumes fields and phase are registered upstream.
module pdc_route
    import pdc_pkg::*;
#(
    parameter int CHAN_W = 3,
    parameter int PWR_W  = 2,
    parameter int NDRV   = 4
) (
    input  phase_t            phase,
    input  logic [CHAN_W-1:0] chan,
    input  logic              single,
    input  logic [PWR_W-1:0]  pwr,
    input  logic              keep,
    output logic [NDRV-1:0]   drv,
    output logic [1:0]        mux_sel,
    output logic              ref_ratio,
    output logic              invalid,
    output logic              analog_pd
);
    // Driver vector bit order: [3]=X+, [2]=X-, [1]=Y+, [0]=Y-.
    localparam int YN_BIT = 0;

    logic [NDRV-1:0] side_mask;
    logic [NDRV-1:0] sense_mask;
    logic            is_x;
    logic            is_y;
    logic            is_aux;
    logic            active;
    logic            between;

    // Channel classification and mux select.
    always_comb begin
        is_x    = (chan == CH_XPOS);
        is_y    = (chan == CH_YPOS);
        is_aux  = (chan == CH_AUX1) || (chan == CH_AUX2);
        invalid = !(is_x || is_y || (is_aux && single));
        unique case (1'b1)
            invalid:           mux_sel = 2'd0;
            is_x:              mux_sel = 2'd0;
            is_y:              mux_sel = 2'd1;
            chan == CH_AUX1:   mux_sel = 2'd2;
            default:           mux_sel = 2'd3;
        endcase
    end

    // Which pair is driven when drive is active.
    assign side_mask = is_x ? 4'b0011 : (is_y ? 4'b1100 : 4'b0000);

    // Drive window depends on phase, reference mode and hold latch.
    assign between = (phase == PH_IDLE) || (phase == PH_ARMED);
    assign active  = (phase == PH_ACQ) ||
                     ((phase == PH_CONV) && (!single || pwr == PWR_HOLD_ON)) ||
                     (between && keep);

    // Idle pen sensing uses the Y- switch only.
    always_comb begin
        sense_mask = '0;
        sense_mask[YN_BIT] = (phase == PH_IDLE) && !keep && !pwr[0];
    end

    // Per-switch gating.
    for (genvar i = 0; i < NDRV; i++) begin : g_sw
        assign drv[i] = (active && side_mask[i]) || sense_mask[i];
    end

    assign ref_ratio = !single && (is_x || is_y);
    assign analog_pd = between && !pwr[1];
endmodule

// File: rtl/pdc_pen.sv
// Module: pen-interrupt pull-down control. Follows the touch comparator
// between commands when enabled, freezes at an accepted start, and is
// released from acquisition to end of conversion.
module pdc_pen
    import pdc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   start_fire,
    input  logic   pen_en,
    input  logic   pen_touch,
    output logic   pen_pull
);
    logic live;
    logic frozen_q;

    assign live = pen_en && pen_touch;

    // Capture the pin value at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)          frozen_q <= 1'b0;
        else if (start_fire) frozen_q <= live;
    end

    // Pin selection by phase.
    always_comb begin
        unique case (phase)
            PH_IDLE:  pen_pull = live;
            PH_ARMED: pen_pull = frozen_q;
            default:  pen_pull = 1'b0;
        endcase
    end
endmodule

// File: rtl/panel_drive_ctrl.sv
// Module: top of the touch panel driver and pen-interrupt controller.
// Connects phase tracker, field store, routing decode and pen control.
// Assumes strobes come from a sequencer clocked by clk.
module panel_drive_ctrl
    import pdc_pkg::*;
#(
    parameter logic [2:0] CHAN_RESET   = 3'b000,
    parameter logic       SINGLE_RESET = 1'b1,
    parameter logic [1:0] PWR_RESET    = 2'b10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_load,
    input  logic [2:0] cfg_chan,
    input  logic       cfg_single,
    input  logic [1:0] cfg_pwr,
    input  logic       start_det,
    input  logic       acq_go,
    input  logic       hold_go,
    input  logic       conv_done,
    input  logic       pen_touch,
    output logic       drv_xp,
    output logic       drv_xn,
    output logic       drv_yp,
    output logic       drv_yn,
    output logic [1:0] mux_sel,
    output logic       ref_ratio,
    output logic       chan_invalid,
    output logic       analog_pd,
    output logic       pen_pull
);
    localparam int CHAN_W = 3;
    localparam int PWR_W  = 2;
    localparam int NDRV   = 4;

    phase_t            phase;
    logic              start_fire;
    logic              done_fire;
    logic [CHAN_W-1:0] chan_q;
    logic              single_q;
    logic [PWR_W-1:0]  pwr_q;
    logic              keep_q;
    logic [NDRV-1:0]   drv;

    pdc_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_det(start_det), .acq_go(acq_go),
        .hold_go(hold_go), .conv_done(conv_done),
        .phase(phase), .start_fire(start_fire), .done_fire(done_fire)
    );

    pdc_cfg_regs #(
        .CHAN_W(CHAN_W), .PWR_W(PWR_W),
        .CHAN_RESET(CHAN_RESET), .SINGLE_RESET(SINGLE_RESET),
        .PWR_RESET(PWR_RESET)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_chan(cfg_chan),
        .cfg_single(cfg_single), .cfg_pwr(cfg_pwr),
        .done_fire(done_fire),
        .chan_q(chan_q), .single_q(single_q), .pwr_q(pwr_q), .keep_q(keep_q)
    );

    pdc_route #(.CHAN_W(CHAN_W), .PWR_W(PWR_W), .NDRV(NDRV)) u_route (
        .phase(phase), .chan(chan_q), .single(single_q), .pwr(pwr_q),
        .keep(keep_q), .drv(drv), .mux_sel(mux_sel), .ref_ratio(ref_ratio),
        .invalid(chan_invalid), .analog_pd(analog_pd)
    );

    pdc_pen u_pen (
        .clk(clk), .rst_n(rst_n), .phase(phase), .start_fire(start_fire),
        .pen_en(!pwr_q[0]), .pen_touch(pen_touch), .pen_pull(pen_pull)
    );

    assign {drv_xp, drv_xn, drv_yp, drv_yn} = drv;
endmodule

// File: rtl/panel_drive_ctrl_chk.sv
// Module: property checker for panel_drive_ctrl, bound to every instance.
module panel_drive_ctrl_chk
    import pdc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input phase_t     phase,
    input logic [1:0] pwr_q,
    input logic       single_q,
    input logic       cfg_load,
    input logic       drv_xp,
    input logic       drv_xn,
    input logic       drv_yp,
    input logic       drv_yn,
    input logic       chan_invalid,
    input logic       analog_pd,
    input logic       pen_pull
);
    // X and Y pairs are never driven together (R2).
    assert_pairs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !((drv_xp || drv_xn) && (drv_yp || drv_yn)));

    // Invalid codes drive nothing during a command (R3).
    assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_invalid && phase != PH_IDLE) |-> !(drv_xp || drv_xn || drv_yp || drv_yn));

    // Single-ended drivers drop once hold is reached (R4).
    assert_single_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && $past(phase) == PH_ACQ && single_q && pwr_q != 2'b11)
        |-> !(drv_xp || drv_xn || drv_yp || drv_yn));

    // Analog section is never powered down while acquiring or converting (R7).
    assert_pd_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACQ || phase == PH_CONV) |-> !analog_pd);

    // Pen pin released from acquisition through conversion (R11).
    assert_pen_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACQ || phase == PH_CONV) |-> !pen_pull);

    // Power field changes only on a load (R12).
    assert_pwr_load_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(pwr_q));
endmodule

bind panel_drive_ctrl panel_drive_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .pwr_q(pwr_q),
    .single_q(single_q), .cfg_load(cfg_load),
    .drv_xp(drv_xp), .drv_xn(drv_xn), .drv_yp(drv_yp), .drv_yn(drv_yn),
    .chan_invalid(chan_invalid), .analog_pd(analog_pd), .pen_pull(pen_pull)
);

// File: tb/panel_drive_ctrl_bench.sv
// Directed bench for panel_drive_ctrl: one task per scenario.
module panel_drive_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_chan = 3'b000;
    logic       cfg_single = 1'b1;
    logic [1:0] cfg_pwr = 2'b10;
    logic       start_det = 1'b0;
    logic       acq_go = 1'b0;
    logic       hold_go = 1'b0;
    logic       conv_done = 1'b0;
    logic       pen_touch = 1'b0;
    logic       drv_xp, drv_xn, drv_yp, drv_yn;
    logic [1:0] mux_sel;
    logic       ref_ratio, chan_invalid, analog_pd, pen_pull;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    panel_drive_ctrl u_panel_drive_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_chan(cfg_chan),
        .cfg_single(cfg_single), .cfg_pwr(cfg_pwr), .start_det(start_det),
        .acq_go(acq_go), .hold_go(hold_go), .conv_done(conv_done),
        .pen_touch(pen_touch), .drv_xp(drv_xp), .drv_xn(drv_xn),
        .drv_yp(drv_yp), .drv_yn(drv_yn), .mux_sel(mux_sel),
        .ref_ratio(ref_ratio), .chan_invalid(chan_invalid),
        .analog_pd(analog_pd), .pen_pull(pen_pull)
    );

    function automatic logic [3:0] drv4();
        return {drv_xp, drv_xn, drv_yp, drv_yn};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a strobe for one cycle; return at the following falling edge.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: start_det = 1'b1;
            1: acq_go    = 1'b1;
            2: hold_go   = 1'b1;
            default: conv_done = 1'b1;
        endcase
        @(negedge clk);
        start_det = 1'b0; acq_go = 1'b0; hold_go = 1'b0; conv_done = 1'b0;
    endtask

    task automatic load(input logic [2:0] ch, input logic se, input logic [1:0] pw);
        @(negedge clk);
        cfg_chan = ch; cfg_single = se; cfg_pwr = pw; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 drivers", drv4(), 4'b0001);
        chk("R1 invalid", chan_invalid, 1);
        chk("R1 analog_pd", analog_pd, 0);
        chk("R1 pen_pull", pen_pull, 0);
        chk("R1 mux_sel", mux_sel, 0);
    endtask

    task automatic t_single_x();
        load(3'b001, 1'b1, 2'b10);
        chk("R2 mux X", mux_sel, 0);
        chk("R6 ref single", ref_ratio, 0);
        pulse(0);
        chk("R4 armed off", drv4(), 4'b0000);
        pulse(1);
        chk("R4 acq Y pair", drv4(), 4'b0011);
        pulse(2);
        chk("R4 hold off", drv4(), 4'b0000);
        pulse(3);
        chk("R8 idle sense", drv4(), 4'b0001);
    endtask

    task automatic t_diff_y();
        load(3'b101, 1'b0, 2'b10);
        chk("R2 mux Y", mux_sel, 1);
        chk("R6 ref ratio", ref_ratio, 1);
        pulse(0); pulse(1);
        chk("R5 acq X pair", drv4(), 4'b1100);
        pulse(2);
        chk("R5 conv on", drv4(), 4'b1100);
        pulse(3);
        chk("R5 after done", drv4(), 4'b0001);
    endtask

    task automatic t_aux_power();
        load(3'b010, 1'b1, 2'b00);
        chk("R2 mux aux1", mux_sel, 2);
        chk("R7 idle pd", analog_pd, 1);
        chk("R8 sense pd00", drv4(), 4'b0001);
        pulse(0);
        chk("R7 armed pd", analog_pd, 1);
        pulse(1);
        chk("R7 acq awake", analog_pd, 0);
        chk("R2 aux no drive", drv4(), 4'b0000);
        pulse(2); pulse(3);
        chk("R7 back pd", analog_pd, 1);
        load(3'b110, 1'b1, 2'b01);
        chk("R2 mux aux2", mux_sel, 3);
        chk("R8 no sense pd01", drv4(), 4'b0000);
        chk("R6 aux ref", ref_ratio, 0);
    endtask

    task automatic t_invalid();
        load(3'b011, 1'b1, 2'b10);
        chk("R3 code011", chan_invalid, 1);
        pulse(0); pulse(1);
        chk("R3 no drive", drv4(), 4'b0000);
        pulse(2); pulse(3);
        load(3'b110, 1'b0, 2'b10);
        chk("R3 diff aux", chan_invalid, 1);
        chk("R3 mux zero", mux_sel, 0);
        load(3'b111, 1'b1, 2'b10);
        chk("R3 code111", chan_invalid, 1);
    endtask

    task automatic t_keep();
        load(3'b101, 1'b1, 2'b11);
        chk("R8 pd11 idle", drv4(), 4'b0000);
        pulse(0); pulse(1); pulse(2);
        chk("R9 single held", drv4(), 4'b1100);
        pulse(3);
        chk("R9 after done", drv4(), 4'b1100);
        chk("R7 pd11 awake", analog_pd, 0);
        load(3'b101, 1'b1, 2'b11);
        chk("R9 same word", drv4(), 4'b1100);
        load(3'b101, 1'b0, 2'b11);
        chk("R9 changed word", drv4(), 4'b0000);
    endtask

    task automatic t_pen();
        load(3'b001, 1'b1, 2'b10);
        pen_touch = 1'b1; #1;
        chk("R10 touch", pen_pull, 1);
        // Touch released in the same cycle as the start strobe.
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0; pen_touch = 1'b0; #1;
        chk("R11 frozen", pen_pull, 1);
        pulse(1);
        pen_touch = 1'b1; #1;
        chk("R11 released", pen_pull, 0);
        pulse(2); pulse(3); #1;
        chk("R10 rearm", pen_pull, 1);
        load(3'b001, 1'b1, 2'b01); #1;
        chk("R10 disabled", pen_pull, 0);
        pen_touch = 1'b0;
    endtask

    task automatic t_rearm();
        // Power field reloaded during the command disables pen afterwards.
        load(3'b001, 1'b1, 2'b10);
        pen_touch = 1'b1;
        pulse(0); pulse(1);
        load(3'b001, 1'b1, 2'b01);
        pulse(2); pulse(3); #1;
        chk("R12 new pwr off", pen_pull, 0);
        // Load colliding with end of conversion enables pen at once.
        pulse(0); pulse(1); pulse(2);
        @(negedge clk);
        conv_done = 1'b1; cfg_load = 1'b1;
        cfg_chan = 3'b001; cfg_single = 1'b1; cfg_pwr = 2'b00;
        @(negedge clk);
        conv_done = 1'b0; cfg_load = 1'b0; #1;
        chk("R12 same cycle pen", pen_pull, 1);
        chk("R12 same cycle pd", analog_pd, 1);
        // Colliding load selects hold-on code: drivers latch on.
        pulse(0); pulse(1); pulse(2);
        @(negedge clk);
        conv_done = 1'b1; cfg_load = 1'b1; cfg_pwr = 2'b11;
        @(negedge clk);
        conv_done = 1'b0; cfg_load = 1'b0;
        chk("R12 same cycle keep", drv4(), 4'b0011);
        load(3'b001, 1'b1, 2'b10);
        pen_touch = 1'b0;
    endtask

    task automatic t_order();
        load(3'b001, 1'b1, 2'b10);
        pulse(1);
        chk("R13 acq in idle", drv4(), 4'b0001);
        pulse(2); pulse(3);
        chk("R13 stray strobes", drv4(), 4'b0001);
        pulse(0); pulse(1); pulse(2);
        pulse(0);
        chk("R13 start in conv", drv4(), 4'b0000);
        pulse(3);
        chk("R13 idle again", drv4(), 4'b0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_x();
        t_diff_y();
        t_aux_power();
        t_invalid();
        t_keep();
        t_pen();
        t_rearm();
        t_order();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule